// File: doc/BRIEF.md
# Two-Port Semaphore Token Unit

This block holds a small bank of binary semaphore flags that two agents, called left and right, use to settle which of them may use a shared resource. Each side has its own port with a semaphore select, a write strobe, a read strobe, an address and a data bus. A side asks for a flag by writing 0 to it and gives the flag up by writing 1. When it reads the flag, it sees 0 if it holds the token and 1 otherwise. The block only coordinates flags; the shared resource sits outside it.

Each flag keeps one request latch per side and a record of which side was granted first. A request from the side that does not hold the token waits as a pending claim. When the holder gives the flag up, the waiting side receives the token with no further write. All state changes on the rising clock edge. Reads are captured into a per-port register when a read opens and held there for as long as that read stays open.

Top module: `sema_token_unit`

## Requirements
- R1: After reset every flag is free, so both ports read 8'hFF from every flag.
- R2: The flag is chosen by address bits [2:0] only; the higher address bits have no effect on which flag a write or a read touches.
- R3: A write with bit 0 = 0 to a free flag gives that side the token in the next cycle: that side then reads 8'h00 and the other side reads 8'hFF.
- R4: A write samples only data bit 0 (0 = request, 1 = release); data bits [7:1] are ignored.
- R5: A request from the side that does not hold the token changes neither side's read value; it is kept as pending.
- R6: When the holder writes 1 while the other side has a pending request, the token moves to the other side at once; with no pending request the flag becomes free and reads 8'hFF on both sides.
- R7: If both sides request a free flag in the same cycle, the left side gets the token and the right request stays pending; a request made in an earlier cycle always wins over a later one.
- R8: Read data carries the flag value on all eight data bits, so it is always 8'h00 or 8'hFF.
- R9: The read value is captured in the first cycle in which select and read strobe are both high, and it stays constant while both stay high; a new value appears only after one of them goes low and the read is opened again.
- R10: A write of 1 from a side that neither holds the flag nor has a pending request on it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_sel | input | 1 | Left semaphore select |
| l_rd_en | input | 1 | Left read strobe |
| l_wr_en | input | 1 | Left write strobe |
| l_addr | input | 14 | Left address; bits [2:0] pick the flag |
| l_wdata | input | 8 | Left write data; bit 0 used |
| l_rdata | output | 8 | Left read data, held per R9 |
| r_sem_sel | input | 1 | Right semaphore select |
| r_rd_en | input | 1 | Right read strobe |
| r_wr_en | input | 1 | Right write strobe |
| r_addr | input | 14 | Right address; bits [2:0] pick the flag |
| r_wdata | input | 8 | Right write data; bit 0 used |
| r_rdata | output | 8 | Right read data, held per R9 |

## Verification
The assertions check on every cycle that granting a free flag, handing a flag over, keeping a pending claim and breaking a same-cycle tie all produce the expected ownership one edge later. They also check that read data is always a full copy of a single bit and that it does not change while a read stays open. The bench's scenarios cover the behaviour that spans several accesses: address aliasing through the high bits, writes of 1 that do nothing, a request sequence across several cycles where the earlier side wins, and a read that is held open across a handover and only shows the new value after it is reopened.

// File: rtl/sema_pkg.sv
package sema_pkg;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // state of one flag: positive-true request latches plus first-granted side
    typedef struct packed {
        logic  want_l;
        logic  want_r;
        side_e holder;
    } flag_state_t;

endpackage

// File: rtl/sema_flag.sv
module sema_flag
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_l,
    input  logic bit_l,
    input  logic wr_r,
    input  logic bit_r,
    output logic view_l,
    output logic view_r
);

    flag_state_t st_d, st_q;
    logic        want_l_n, want_r_n, any_old;

    always_comb begin
        st_d     = st_q;
        want_l_n = wr_l ? ~bit_l : st_q.want_l;
        want_r_n = wr_r ? ~bit_r : st_q.want_r;
        any_old  = st_q.want_l | st_q.want_r;
        st_d.want_l = want_l_n;
        st_d.want_r = want_r_n;
        if (want_l_n && want_r_n) begin
            // earlier holder keeps it; exact tie goes left
            st_d.holder = any_old ? st_q.holder : SIDE_LEFT;
        end else if (want_l_n) begin
            st_d.holder = SIDE_LEFT;
        end else if (want_r_n) begin
            st_d.holder = SIDE_RIGHT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{want_l: 1'b0, want_r: 1'b0, holder: SIDE_LEFT};
        end else begin
            st_q <= st_d;
        end
    end

    // active-low views: 0 means this side holds the token
    assign view_l = ~(st_q.want_l && (st_q.holder == SIDE_LEFT));
    assign view_r = ~(st_q.want_r && (st_q.holder == SIDE_RIGHT));

    logic is_free;
    assign is_free = !st_q.want_l && !st_q.want_r;

    // R3: lone request on a free flag is granted
    a_r3_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
        (is_free && wr_l && !bit_l && !(wr_r && !bit_r)) |=> (!view_l && view_r));

    // R5: a request from the non-holder leaves both views alone
    a_r5_pending_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!view_l && wr_r && !bit_r && !wr_l) |=> (!view_l && view_r));

    // R6: holder release with pending claim hands over
    a_r6_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (!view_l && st_q.want_r && wr_l && bit_l && !wr_r) |=> (view_l && !view_r));

    // R7: same-cycle requests on a free flag go left
    a_r7_tie_left: assert property (@(posedge clk) disable iff (!rst_n)
        (is_free && wr_l && !bit_l && wr_r && !bit_r) |=> (!view_l && view_r));

endmodule

// File: rtl/sema_rd_port.sv
module sema_rd_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_open,
    input  logic              flag_val,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic              was_open;
        logic [DATA_W-1:0] held;
    } rd_state_t;

    rd_state_t rs_d, rs_q;

    always_comb begin
        rs_d          = rs_q;
        rs_d.was_open = rd_open;
        if (rd_open && !rs_q.was_open) begin
            rs_d.held = {DATA_W{flag_val}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '{was_open: 1'b0, held: {DATA_W{1'b1}}};
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rdata = rs_q.held;

    // R8: data is always a full copy of one bit
    a_r8_replicated: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata == '0) || (rdata == '1));

    // R9: an open read keeps its captured value
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_open && rs_q.was_open) |=> $stable(rdata));

endmodule

// File: rtl/sema_token_unit.sv
module sema_token_unit
    import sema_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_sel,
    input  logic              l_rd_en,
    input  logic              l_wr_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_sel,
    input  logic              r_rd_en,
    input  logic              r_wr_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int SEL_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;

    logic [SEL_W-1:0]     l_idx, r_idx;
    logic [NUM_FLAGS-1:0] view_l_vec, view_r_vec;
    logic                 l_wr, r_wr;

    assign l_idx = l_addr[SEL_W-1:0];
    assign r_idx = r_addr[SEL_W-1:0];
    assign l_wr  = l_sem_sel && l_wr_en;
    assign r_wr  = r_sem_sel && r_wr_en;

    // upper address and data bits take no part in semaphore access
    logic unused_bits;
    assign unused_bits = ^{l_addr[ADDR_W-1:SEL_W], r_addr[ADDR_W-1:SEL_W],
                           l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        sema_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_l   (l_wr && (l_idx == SEL_W'(gi))),
            .bit_l  (l_wdata[0]),
            .wr_r   (r_wr && (r_idx == SEL_W'(gi))),
            .bit_r  (r_wdata[0]),
            .view_l (view_l_vec[gi]),
            .view_r (view_r_vec[gi])
        );
    end

    sema_rd_port #(.DATA_W(DATA_W)) u_rd_l (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_open  (l_sem_sel && l_rd_en),
        .flag_val (view_l_vec[l_idx]),
        .rdata    (l_rdata)
    );

    sema_rd_port #(.DATA_W(DATA_W)) u_rd_r (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_open  (r_sem_sel && r_rd_en),
        .flag_val (view_r_vec[r_idx]),
        .rdata    (r_rdata)
    );

endmodule

// File: tb/sim_sema_token_unit.sv
`timescale 1ns/1ps
module sim_sema_token_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        l_sem_sel, l_rd_en, l_wr_en;
    logic [13:0] l_addr;
    logic [7:0]  l_wdata, l_rdata;
    logic        r_sem_sel, r_rd_en, r_wr_en;
    logic [13:0] r_addr;
    logic [7:0]  r_wdata, r_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sema_token_unit u0 (.*);

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input bit right, input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        if (right) begin r_sem_sel = 1; r_wr_en = 1; r_addr = a; r_wdata = d; end
        else       begin l_sem_sel = 1; l_wr_en = 1; l_addr = a; l_wdata = d; end
        @(negedge clk);
        r_sem_sel = 0; r_wr_en = 0; l_sem_sel = 0; l_wr_en = 0;
    endtask

    task automatic wr_both(input logic [13:0] a, input logic [7:0] dl, input logic [7:0] dr);
        @(negedge clk);
        l_sem_sel = 1; l_wr_en = 1; l_addr = a; l_wdata = dl;
        r_sem_sel = 1; r_wr_en = 1; r_addr = a; r_wdata = dr;
        @(negedge clk);
        r_sem_sel = 0; r_wr_en = 0; l_sem_sel = 0; l_wr_en = 0;
    endtask

    task automatic rd_chk(input string tag, input bit right, input logic [13:0] a,
                          input logic [7:0] exp);
        @(negedge clk);
        if (right) begin r_sem_sel = 1; r_rd_en = 1; r_addr = a; end
        else       begin l_sem_sel = 1; l_rd_en = 1; l_addr = a; end
        @(negedge clk);
        check(tag, right ? r_rdata : l_rdata, exp);
        r_sem_sel = 0; r_rd_en = 0; l_sem_sel = 0; l_rd_en = 0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) begin
            rd_chk("R1 left free after reset", 0, 14'(i), 8'hFF);
            rd_chk("R1 right free after reset", 1, 14'(i), 8'hFF);
        end
    endtask

    task automatic t_grant;
        wr(0, 14'd2, 8'h00);
        rd_chk("R3 left holds, r8_ all zeros", 0, 14'd2, 8'h00);
        rd_chk("R3 right sees taken", 1, 14'd2, 8'hFF);
        wr(0, 14'd2, 8'h01);
        rd_chk("R6 free after release left", 0, 14'd2, 8'hFF);
        rd_chk("R6 free after release right", 1, 14'd2, 8'hFF);
    endtask

    task automatic t_bit0;
        wr(1, 14'd5, 8'hFE);
        rd_chk("R4 bit0=0 requests", 1, 14'd5, 8'h00);
        rd_chk("R4 left sees taken", 0, 14'd5, 8'hFF);
        wr(1, 14'd5, 8'h01);
        rd_chk("R4 bit0=1 releases", 1, 14'd5, 8'hFF);
    endtask

    task automatic t_addr;
        wr(0, 14'h3FF9, 8'h00);
        rd_chk("R2 high bits alias left", 0, 14'h2001, 8'h00);
        rd_chk("R2 right flag1", 1, 14'h0001, 8'hFF);
        rd_chk("R2 neighbour untouched", 1, 14'h0000, 8'hFF);
        wr(0, 14'h0001, 8'h01);
        rd_chk("R2 release via alias", 1, 14'h1001, 8'hFF);
    endtask

    task automatic t_pending;
        wr(0, 14'd3, 8'h00);
        wr(1, 14'd3, 8'h00);
        rd_chk("R5 left still holds", 0, 14'd3, 8'h00);
        rd_chk("R5 right pending reads 1", 1, 14'd3, 8'hFF);
        wr(0, 14'd3, 8'h01);
        rd_chk("R6 handover right holds", 1, 14'd3, 8'h00);
        rd_chk("R6 handover left sees taken", 0, 14'd3, 8'hFF);
        wr(1, 14'd3, 8'h01);
        rd_chk("R6 freed after handover", 0, 14'd3, 8'hFF);
    endtask

    task automatic t_ignore;
        wr(0, 14'd4, 8'h00);
        wr(1, 14'd4, 8'h01);
        rd_chk("R10 left keeps token", 0, 14'd4, 8'h00);
        rd_chk("R10 right unchanged", 1, 14'd4, 8'hFF);
        wr(0, 14'd4, 8'h01);
        rd_chk("R10 no pending created", 1, 14'd4, 8'hFF);
    endtask

    task automatic t_tie;
        wr_both(14'd6, 8'h00, 8'h00);
        rd_chk("R7 tie left wins", 0, 14'd6, 8'h00);
        rd_chk("R7 tie right loses", 1, 14'd6, 8'hFF);
        wr(0, 14'd6, 8'h01);
        rd_chk("R7 loser kept pending", 1, 14'd6, 8'h00);
        wr(1, 14'd6, 8'h01);
        wr(1, 14'd7, 8'h00);
        wr(0, 14'd7, 8'h00);
        rd_chk("R7 earlier right wins", 1, 14'd7, 8'h00);
        rd_chk("R7 later left waits", 0, 14'd7, 8'hFF);
        wr(1, 14'd7, 8'h01);
        wr(0, 14'd7, 8'h01);
        rd_chk("R7 flag7 freed", 1, 14'd7, 8'hFF);
    endtask

    task automatic t_freeze;
        wr(0, 14'd0, 8'h00);
        wr(1, 14'd0, 8'h00);
        @(negedge clk);
        r_sem_sel = 1; r_rd_en = 1; r_addr = 14'd0;
        @(negedge clk);
        check("R9 first capture", r_rdata, 8'hFF);
        l_sem_sel = 1; l_wr_en = 1; l_addr = 14'd0; l_wdata = 8'h01;
        @(negedge clk);
        l_sem_sel = 0; l_wr_en = 0;
        @(negedge clk);
        @(negedge clk);
        check("R9 held across handover", r_rdata, 8'hFF);
        r_rd_en = 0;
        @(negedge clk);
        r_rd_en = 1;
        @(negedge clk);
        check("R9 refreshed after reopen", r_rdata, 8'h00);
        r_sem_sel = 0; r_rd_en = 0;
        wr(1, 14'd0, 8'h01);
        rd_chk("R9 flag0 freed", 0, 14'd0, 8'hFF);
    endtask

    initial begin
        rst_n = 0;
        l_sem_sel = 0; l_rd_en = 0; l_wr_en = 0; l_addr = '0; l_wdata = '0;
        r_sem_sel = 0; r_rd_en = 0; r_wr_en = 0; r_addr = '0; r_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 left data at reset", l_rdata, 8'hFF);
        check("R1 right data at reset", r_rdata, 8'hFF);
        t_reset();
        t_grant();
        t_bit0();
        t_addr();
        t_pending();
        t_ignore();
        t_tie();
        t_freeze();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule